// File: doc/BRIEF.md
# Opcode-Driven Arithmetic Logic Unit

This block is a purely combinational integer ALU of parameterised width. A three-bit function code picks one of six operations on two operands: bitwise AND, bitwise OR, addition, AND with the complemented second operand, OR with the complemented second operand, and subtraction. The top bit of the code conditionally complements the second operand before it reaches both the logic stage and the single ripple adder. The same bit also feeds the adder's carry-in. That shared path is how one adder serves for both addition and two's-complement subtraction.

The low two bits of the code choose which stage drives the result: the AND stage, the OR stage or the adder. Alongside the result the block reports three flags: carry-out, signed overflow and a zero flag. The two codes with low bits 11 do not select any stage and give a fully defined all-zero result. The block sits in a datapath wherever a small, shallow operation unit is needed, and it adds no pipeline stage.

Top module: `alu_core`

## Requirements
- R1: Function code 000 gives result = opA AND opB.
- R2: Function code 001 gives result = opA OR opB.
- R3: Function code 010 gives result = (opA + opB) modulo 2^WIDTH, and carryOut equals bit WIDTH of the unsigned sum.
- R4: Function code 100 gives result = opA AND (NOT opB).
- R5: Function code 101 gives result = opA OR (NOT opB).
- R6: Function code 110 gives result = (opA - opB) modulo 2^WIDTH, formed as opA + NOT opB + 1. carryOut is bit WIDTH of that sum, so it is 1 when no borrow occurs.
- R7: Function codes 011 and 111 give result = 0, carryOut = 0 and overflow = 0.
- R8: For codes 010 and 110, overflow is 1 exactly when the carry into the most significant bit differs from the carry out of it. This is the same as both adder inputs sharing a sign that the result does not share. For every other code, overflow is 0.
- R9: isZero is 1 exactly when every bit of result is 0, for every function code.
- R10: carryOut is 0 for the logic codes 000, 001, 100 and 101.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opA | input | WIDTH | First operand |
| opB | input | WIDTH | Second operand, complemented when funcCode[2] is 1 |
| funcCode | input | 3 | Operation select; bit 2 = complement opB and set carry-in, bits 1:0 = 00 AND, 01 OR, 10 adder, 11 unused |
| result | output | WIDTH | Operation result |
| carryOut | output | 1 | Adder carry out of the top bit, add and subtract only |
| overflow | output | 1 | Signed overflow, add and subtract only |
| isZero | output | 1 | High when result is all zeros |

## Verification
No register lies between the inputs and the outputs, so every result and flag is due in the same cycle as the operands and code that produce it. The bench drives each new stimulus just after a falling clock edge and samples one nanosecond later, well before the next rising edge. It compares all four outputs against a behavioural model evaluated on that same stimulus. Each cycle carries one stimulus. Each code in turn meets the boundary operands (zero, one, all ones, the largest positive value and the most negative value), and then random operands follow under random codes.

// File: rtl/alu_pkg.sv
package alu_pkg;

  // Strobes passed from the decoder to the datapath
  typedef struct packed {
    logic invertB;   // complement second operand
    logic carryIn;   // adder carry into bit 0
    logic selAnd;    // result from AND stage
    logic selOr;     // result from OR stage
    logic selAdd;    // result from adder
  } alu_ctrl_t;

  localparam int FUNC_W = 3;

endpackage

// File: rtl/alu_ctrl.sv
module alu_ctrl
  import alu_pkg::*;
(
  input  logic [FUNC_W-1:0] funcCode,
  output alu_ctrl_t         ctrl
);

  logic [1:0] stageSel;

  assign stageSel = funcCode[1:0];

  always_comb begin
    ctrl.invertB = funcCode[2];
    ctrl.carryIn = funcCode[2];
    ctrl.selAnd  = (stageSel == 2'b00);
    ctrl.selOr   = (stageSel == 2'b01);
    ctrl.selAdd  = (stageSel == 2'b10);
  end

  always_comb begin
    // R7
    single_stage_chk: assert ($onehot0({ctrl.selAnd, ctrl.selOr, ctrl.selAdd}))
      else $error("more than one result stage selected");
  end

endmodule

// File: rtl/alu_datapath.sv
module alu_datapath
  import alu_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  alu_ctrl_t        ctrl,
  output logic [WIDTH-1:0] result,
  output logic             carryOut,
  output logic             overflow,
  output logic             isZero
);

  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] bMod;
  logic [WIDTH-1:0] sumBits;
  logic [WIDTH-1:0] andBits;
  logic [WIDTH-1:0] orBits;
  logic [WIDTH:0]   carryChain;

  // One conditional inverter shared by logic and arithmetic
  assign bMod          = ctrl.invertB ? ~opB : opB;
  assign carryChain[0] = ctrl.carryIn;

  generate
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      logic genBit;
      logic propBit;
      assign genBit          = opA[i] & bMod[i];
      assign propBit         = opA[i] ^ bMod[i];
      assign sumBits[i]      = propBit ^ carryChain[i];
      assign carryChain[i+1] = genBit | (propBit & carryChain[i]);
    end
  endgenerate

  assign andBits = opA & bMod;
  assign orBits  = opA | bMod;

  always_comb begin
    result = '0;
    if (ctrl.selAnd) result = andBits;
    if (ctrl.selOr)  result = orBits;
    if (ctrl.selAdd) result = sumBits;
  end

  assign carryOut = ctrl.selAdd & carryChain[WIDTH];
  assign overflow = ctrl.selAdd & (carryChain[WIDTH] ^ carryChain[MSB]);
  assign isZero   = ~|result;

  always_comb begin
    if (ctrl.selAdd && !ctrl.invertB) begin
      // R3
      sum_add_chk: assert (result == WIDTH'(opA + opB))
        else $error("adder sum mismatch");
    end
    if (ctrl.selAdd && ctrl.invertB) begin
      // R6
      sum_sub_chk: assert (result == WIDTH'(opA - opB))
        else $error("subtract mismatch");
    end
    if (!ctrl.selAnd && !ctrl.selOr && !ctrl.selAdd) begin
      // R7
      unused_zero_chk: assert (result == '0 && !carryOut && !overflow)
        else $error("unused code output not zero");
    end
    if (!ctrl.selAdd) begin
      // R8
      no_overflow_chk: assert (!overflow)
        else $error("overflow raised outside arithmetic");
      // R10
      no_carry_chk: assert (!carryOut)
        else $error("carry raised outside arithmetic");
    end
  end

endmodule

// File: rtl/alu_core.sv
module alu_core
  import alu_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0]  opA,
  input  logic [WIDTH-1:0]  opB,
  input  logic [FUNC_W-1:0] funcCode,
  output logic [WIDTH-1:0]  result,
  output logic              carryOut,
  output logic              overflow,
  output logic              isZero
);

  alu_ctrl_t ctrlStrobes;

  alu_ctrl ctrl_i (
    .funcCode (funcCode),
    .ctrl     (ctrlStrobes)
  );

  alu_datapath #(.WIDTH(WIDTH)) dp_i (
    .opA      (opA),
    .opB      (opB),
    .ctrl     (ctrlStrobes),
    .result   (result),
    .carryOut (carryOut),
    .overflow (overflow),
    .isZero   (isZero)
  );

  always_comb begin
    // R9
    zero_flag_chk: assert (isZero == (result == '0))
      else $error("zero flag disagrees with result");
  end

endmodule

// File: tb/alu_core_tb.sv
module alu_core_tb_top;

  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] opA = '0;
  logic [W-1:0] opB = '0;
  logic [2:0]   funcCode = 3'b011;
  logic [W-1:0] result;
  logic         carryOut;
  logic         overflow;
  logic         isZero;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  alu_core #(.WIDTH(W)) dut_i (
    .opA      (opA),
    .opB      (opB),
    .funcCode (funcCode),
    .result   (result),
    .carryOut (carryOut),
    .overflow (overflow),
    .isZero   (isZero)
  );

  task automatic check(input string req, input string what,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s code=%b a=%h b=%h actual=%h expected=%h",
               req, what, funcCode, opA, opB, act, exp);
    end
  endtask

  // Behavioural model evaluated per stimulus
  task automatic apply(input logic [2:0] f, input logic [W-1:0] a, input logic [W-1:0] b);
    logic [W-1:0] bm;
    logic [W:0]   wide;
    logic [W-1:0] expY;
    logic         expC;
    logic         expV;
    string        tag;
    @(negedge clk);
    funcCode = f;
    opA = a;
    opB = b;
    #1;
    bm = f[2] ? ~b : b;
    expC = 1'b0;
    expV = 1'b0;
    case (f)
      3'b000: begin expY = a & b;  tag = "R1"; end
      3'b001: begin expY = a | b;  tag = "R2"; end
      3'b100: begin expY = a & ~b; tag = "R4"; end
      3'b101: begin expY = a | ~b; tag = "R5"; end
      3'b010, 3'b110: begin
        wide = {1'b0, a} + {1'b0, bm} + {{W{1'b0}}, f[2]};
        expY = wide[W-1:0];
        expC = wide[W];
        expV = (a[W-1] == bm[W-1]) && (expY[W-1] != a[W-1]);
        tag  = f[2] ? "R6" : "R3";
      end
      default: begin expY = '0; tag = "R7"; end
    endcase
    check(tag, "result", result, expY);
    check((f[1:0] == 2'b10) ? tag : ((f[1:0] == 2'b11) ? "R7" : "R10"),
          "carryOut", {{(W-1){1'b0}}, carryOut}, {{(W-1){1'b0}}, expC});
    check("R8", "overflow", {{(W-1){1'b0}}, overflow}, {{(W-1){1'b0}}, expV});
    check("R9", "isZero", {{(W-1){1'b0}}, isZero}, {{(W-1){1'b0}}, (expY == '0)});
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000 && !done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=%0d expected<=100000", cycles);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] edges [5];
    edges[0] = '0;
    edges[1] = W'(1);
    edges[2] = '1;
    edges[3] = {1'b0, {(W-1){1'b1}}};
    edges[4] = {1'b1, {(W-1){1'b0}}};
    repeat (3) @(posedge clk);
    // reset state: idle code with zero operands
    #1;
    check("R7", "reset result", result, '0);
    check("R9", "reset isZero", {{(W-1){1'b0}}, isZero}, {{(W-1){1'b0}}, 1'b1});
    rst_n = 1'b1;
    // R3 R6 R8 boundary cases: max positive, most negative, all ones
    for (int f = 0; f < 8; f++)
      for (int i = 0; i < 5; i++)
        for (int j = 0; j < 5; j++)
          apply(3'(f), edges[i], edges[j]);
    // R9 equal operands under subtract give zero
    apply(3'b110, 16'h1234, 16'h1234);
    // R6 borrow case
    apply(3'b110, 16'h0004, 16'h0007);
    // random sweep covering R1..R10
    for (int k = 0; k < 3000; k++)
      apply(3'($urandom_range(0, 7)), W'($urandom), W'($urandom));
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule